// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a register-mapped SPI master that runs one command each time software triggers it. Software places an 8-bit command opcode in the control word. It puts the outgoing payload bytes into a small shared byte buffer and programs an outgoing byte count, an incoming byte count and a target select index. A single execute bit then starts the command.

The engine pulls the selected chip-select line low and keeps it low for the whole command. It shifts out the opcode and then the payload bytes, MSB first, in SPI mode 0 with SCLK at one quarter of the system clock. It then clocks in the requested number of response bytes. Each response byte is written back into the same buffer, directly behind the outgoing payload. The line is half duplex, so whatever the target drives while the engine is still talking is thrown away. Software polls a busy flag and, once the flag drops, reads the response out of the buffer.

An internal buffer pointer chooses where the outgoing payload starts and where responses land. A clear bit in the control word sets the pointer back to zero. Software normally writes this bit before each command.

Top module: `spicmd_engine`

## Requirements
- R1: After reset every register reads zero, all chip-select outputs are high (inactive), and SCLK and MOSI are low.
- R2: Register map (byte addresses on bus_addr). Control at 0x00: opcode in bits [7:0], execute in bit 16 (self-clearing, reads 0), pointer clear in bit 20 (write-only), busy in bit 31 (read-only). Chip-select index at 0x1D, bits [1:0], upper bits read 0. Outgoing count at 0x48 and incoming count at 0x4B, 8 bits each. Buffer byte k (0..69) at 0x80+k. Any other address reads 0.
- R3: Writing 1 to bit 16 while idle makes busy read 1 from the next cycle on. During the command exactly the chip-select output named by the index is low, with a single falling edge. Busy clears one cycle after that line returns high.
- R4: On the wire the opcode goes first, then the outgoing-count bytes read from the buffer starting at the pointer, then the incoming-count bytes, all MSB first. A command puts exactly 1 + out + in bytes on the wire.
- R5: Incoming byte i is stored at buffer index out + i (pointer-relative), so after a cleared pointer it reads back at 0x80 + out + i.
- R6: MISO data seen during the opcode and outgoing phases is discarded and the outgoing payload in the buffer is left intact. MOSI is 0 during the incoming phase.
- R7: SCLK idles low, is high for exactly 2 system clocks per bit, and consecutive rising edges within a byte are 4 system clocks apart (mode 0: the target drives on the falling edge and the engine samples on the rising edge).
- R8: Writing 1 to bit 20 resets the pointer to 0. Without it a command starts at the pointer the previous command left, which is previous out + previous in.
- R9: While busy, every bus write (buffer, counts, chip-select index, opcode, execute, clear) is ignored.
- R10: Incoming bytes whose index would be 70 or more are not stored, but their 8 clocks still run.
- R11: With both counts zero only the opcode byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 4 | Active-low chip selects, one per target |

## Verification
The bench's target model answers every wire byte with a value derived from the byte's position. If a design stored data from the opcode or outgoing phases, or placed responses at the wrong index, the buffer readback would differ. A command with 60 outgoing and 20 incoming bytes tests the end of the buffer. A design that wrapped or kept writing past index 69 would corrupt the payload, and one that dropped the extra clocks would show a short byte count. Further tests fire writes and a second execute in the middle of a command, and run a command without clearing the pointer. A design that let these writes through, or that reset the pointer by itself, would send the wrong payload byte or pulse the chip select twice.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CSEL = 8'h1D;
    localparam logic [7:0] OFS_TXN  = 8'h48;
    localparam logic [7:0] OFS_RXN  = 8'h4B;
    localparam logic [7:0] OFS_FIFO = 8'h80;

    localparam int BIT_EXEC  = 16;
    localparam int BIT_CLR   = 20;
    localparam int BIT_BUSY  = 31;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_END} seq_st_t;
    typedef enum logic [1:0] {PH_OPC, PH_TX, PH_RX} phase_t;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] txn;
        logic [BYTE_W-1:0] rxn;
    } cmd_t;

    function automatic logic addr_hits_fifo(input logic [7:0] a, input logic [7:0] depth);
        logic [7:0] o;
        o = a - OFS_FIFO;
        return (a >= OFS_FIFO) && (o < depth);
    endfunction

endpackage

// File: rtl/spicmd_fifo.sv
module spicmd_fifo #(
    parameter int DEPTH = 70,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wbyte,
    input  logic [AW-1:0] ridx_a,
    output logic [7:0]    rbyte_a,
    input  logic [AW-1:0] ridx_b,
    output logic [7:0]    rbyte_b
);
    localparam int IDXW = $clog2(DEPTH);
    localparam logic [AW-1:0] LIM = AW'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we && (widx < LIM)) begin
            mem[widx[IDXW-1:0]] <= wbyte;
        end
    end

    assign rbyte_a = (ridx_a < LIM) ? mem[ridx_a[IDXW-1:0]] : 8'h00;
    assign rbyte_b = (ridx_b < LIM) ? mem[ridx_b[IDXW-1:0]] : 8'h00;

    // R10: no write is ever aimed beyond the last entry
    p_idx_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        we |-> (widx < LIM));

endmodule

// File: rtl/spicmd_shift.sv
module spicmd_shift #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       done,
    output logic [7:0] dout
);
    localparam int HALF = DIV / 2;
    localparam int QW   = $clog2(DIV);

    logic [QW-1:0] q;
    logic [2:0]    nb;
    logic [7:0]    txs, rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            q      <= '0;
            nb     <= '0;
            txs    <= '0;
            rxs    <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    txs    <= din;
                    q      <= '0;
                    nb     <= '0;
                end
            end else begin
                q <= (q == QW'(DIV-1)) ? '0 : q + 1'b1;
                if (q == QW'(HALF-1)) rxs <= {rxs[6:0], miso};
                if (q == QW'(DIV-1)) begin
                    txs <= {txs[6:0], 1'b0};
                    nb  <= nb + 1'b1;
                    if (nb == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign sclk = active && (q >= QW'(HALF));
    assign mosi = active && txs[7];
    assign dout = rxs;

    // R4: a new byte is only launched when the previous one is finished
    p_start_idle_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
    // R7: a byte end marker follows an active shift
    p_done_after_shift_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active));

endmodule

// File: rtl/spicmd_seq.sv
module spicmd_seq
    import spicmd_pkg::*;
#(
    parameter int DEPTH = 70,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          clr,
    input  cmd_t          cmd,
    output logic [AW-1:0] ptr,
    input  logic [7:0]    fifo_byte,
    output logic          fifo_we,
    output logic [7:0]    fifo_wbyte,
    output logic          sh_start,
    output logic [7:0]    sh_din,
    input  logic          sh_done,
    input  logic [7:0]    sh_dout,
    output logic          busy,
    output logic          cs_en
);
    localparam logic [AW-1:0] LIM = AW'(DEPTH);

    seq_st_t     state;
    phase_t      phase;
    logic [7:0]  left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_OPC;
            left  <= '0;
            ptr   <= '0;
            busy  <= 1'b0;
            cs_en <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clr) ptr <= '0;
                    if (go) begin
                        busy  <= 1'b1;
                        cs_en <= 1'b1;
                        phase <= PH_OPC;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        if (phase != PH_OPC) ptr <= ptr + 1'b1;
                        if (phase == PH_OPC) begin
                            if (cmd.txn != 0) begin
                                phase <= PH_TX; left <= cmd.txn; state <= ST_LOAD;
                            end else if (cmd.rxn != 0) begin
                                phase <= PH_RX; left <= cmd.rxn; state <= ST_LOAD;
                            end else begin
                                state <= ST_END; cs_en <= 1'b0;
                            end
                        end else if (left == 8'd1) begin
                            if (phase == PH_TX && cmd.rxn != 0) begin
                                phase <= PH_RX; left <= cmd.rxn; state <= ST_LOAD;
                            end else begin
                                state <= ST_END; cs_en <= 1'b0;
                            end
                        end else begin
                            left  <= left - 1'b1;
                            state <= ST_LOAD;
                        end
                    end
                end
                default: begin
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign sh_start   = (state == ST_LOAD);
    assign sh_din     = (phase == PH_OPC) ? cmd.opcode :
                        (phase == PH_TX)  ? fifo_byte  : 8'h00;
    assign fifo_we    = (state == ST_WAIT) && sh_done && (phase == PH_RX) && (ptr < LIM);
    assign fifo_wbyte = sh_dout;

    // R3: chip select is only driven inside a busy window
    p_cs_within_busy_r3: assert property (@(posedge clk) disable iff (rst)
        cs_en |-> busy);
    // R8: a clear seen while idle leaves the pointer at zero
    p_ptr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && clr) |=> (ptr == '0));

endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine
    import spicmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 70,
    parameter int NCS        = 4,
    parameter int SCLK_DIV   = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    localparam int CSW = $clog2(NCS);
    localparam int AW  = 9;
    localparam logic [7:0] DEPTH8 = 8'(FIFO_DEPTH);

    cmd_t           cmd;
    logic [CSW-1:0] csel;
    logic           busy, cs_en;
    logic           wr_ok, go, clr, bus_fw, hit_fifo;
    logic [AW-1:0]  ptr, bus_idx, fifo_widx;
    logic [7:0]     fifo_eng_rd, fifo_bus_rd, fifo_wbyte, eng_wbyte;
    logic           eng_we, fifo_we;
    logic           sh_start, sh_done, sh_active;
    logic [7:0]     sh_din, sh_dout;
    logic           unused_bits;

    assign unused_bits = ^{bus_wdata[31:21], bus_wdata[19:17], bus_wdata[15:8], sh_active};

    assign wr_ok    = bus_wr && !busy;
    assign hit_fifo = addr_hits_fifo(bus_addr, DEPTH8);
    assign go       = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[BIT_EXEC];
    assign clr      = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[BIT_CLR];
    assign bus_fw   = wr_ok && hit_fifo;
    assign bus_idx  = AW'(bus_addr - OFS_FIFO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '0;
            csel <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                OFS_CTRL: cmd.opcode <= bus_wdata[7:0];
                OFS_CSEL: csel       <= bus_wdata[CSW-1:0];
                OFS_TXN:  cmd.txn    <= bus_wdata[7:0];
                OFS_RXN:  cmd.rxn    <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[7:0]      = cmd.opcode;
                bus_rdata[BIT_BUSY] = busy;
            end
            OFS_CSEL: bus_rdata[CSW-1:0] = csel;
            OFS_TXN:  bus_rdata[7:0]     = cmd.txn;
            OFS_RXN:  bus_rdata[7:0]     = cmd.rxn;
            default:  if (hit_fifo) bus_rdata[7:0] = fifo_bus_rd;
        endcase
    end

    assign fifo_we    = bus_fw | eng_we;
    assign fifo_widx  = busy ? ptr : bus_idx;
    assign fifo_wbyte = busy ? eng_wbyte : bus_wdata[7:0];

    spicmd_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_fifo (
        .clk(clk), .rst(rst), .we(fifo_we), .widx(fifo_widx), .wbyte(fifo_wbyte),
        .ridx_a(ptr), .rbyte_a(fifo_eng_rd), .ridx_b(bus_idx), .rbyte_b(fifo_bus_rd)
    );

    spicmd_seq #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .go(go), .clr(clr), .cmd(cmd), .ptr(ptr),
        .fifo_byte(fifo_eng_rd), .fifo_we(eng_we), .fifo_wbyte(eng_wbyte),
        .sh_start(sh_start), .sh_din(sh_din), .sh_done(sh_done), .sh_dout(sh_dout),
        .busy(busy), .cs_en(cs_en)
    );

    spicmd_shift #(.DIV(SCLK_DIV)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .din(sh_din), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .active(sh_active), .done(sh_done), .dout(sh_dout)
    );

    for (genvar k = 0; k < NCS; k++) begin : g_cs
        assign spi_cs_n[k] = !(cs_en && (csel == CSW'(k)));
    end

    // R3: at most one target selected at a time
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));
    // R3: no target selected while idle
    p_idle_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&spi_cs_n));
    // R3: an accepted execute raises busy on the next cycle
    p_go_busy_r3: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);
    // R7: the serial clock only toggles with a target selected
    p_sclk_cs_r7: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !(&spi_cs_n));
    // R9: command registers hold still for the whole busy window
    p_hold_regs_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cmd) && $stable(csel)));

endmodule

// File: tb/sim_spicmd_engine.sv
module sim_spicmd_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;

    spicmd_engine u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    function automatic logic [7:0] resp(input int k);
        return 8'((k * 29 + 53) & 255);
    endfunction

    wire cs_idle = &spi_cs_n;
    logic [7:0] mosi_log [300];
    logic [7:0] cap = 8'h00;
    int nbytes = 0, slv_k = 0, slv_bit = 0, cs_falls = 0;
    logic [3:0] lowmask = 4'h0;

    always @(negedge cs_idle) begin
        logic [7:0] t;
        slv_k = 0; slv_bit = 0; nbytes = 0; cs_falls++;
        t = resp(0);
        spi_miso = t[7];
    end

    always @(posedge spi_sclk) begin
        cap = {cap[6:0], spi_mosi};
        slv_bit++;
        if (slv_bit == 8) begin
            if (nbytes < 300) mosi_log[nbytes] = cap;
            nbytes++; slv_bit = 0; slv_k++;
        end
    end

    always @(negedge spi_sclk) begin
        logic [7:0] t;
        if (!cs_idle) begin
            t = resp(slv_k);
            spi_miso = t[7 - slv_bit];
        end
    end

    // ---------------- clock-shape monitor ----------------
    int cyc = 0, last_rise = -1, min_int = 1000, hi_run = 0, hi_min = 1000, hi_max = 0;
    logic prev_s = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!cs_idle) lowmask |= ~spi_cs_n;
        if (spi_sclk && !prev_s) begin
            if (last_rise >= 0 && (cyc - last_rise) < min_int) min_int = cyc - last_rise;
            last_rise = cyc;
        end
        if (spi_sclk) hi_run++;
        else if (prev_s) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        prev_s = spi_sclk;
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h00, d);
            if (!d[31]) return;
        end
        chk(1'b0, "R3", "busy never cleared", 1, 0);
    endtask

    task automatic launch(input logic [7:0] op, input logic [1:0] cs,
                          input logic [7:0] tx, input logic [7:0] rx, input bit doclr);
        logic [31:0] d;
        wr(8'h1D, {30'h0, cs});
        wr(8'h48, {24'h0, tx});
        wr(8'h4B, {24'h0, rx});
        if (doclr) wr(8'h00, 32'h0010_0000 | op);
        cs_falls = 0; lowmask = 4'h0;
        wr(8'h00, 32'h0001_0000 | op);
        rd(8'h00, d);
        chk(d[31] == 1'b1, "R3", "busy after execute", d[31], 1);
    endtask

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'((v * 37 + i * 11 + 3) & 255);
    endfunction

    // {opcode, tx count, rx count, chip select}
    localparam logic [31:0] VEC [5] = '{
        {8'h9F, 8'd0,  8'd3,  8'd0},
        {8'h03, 8'd3,  8'd4,  8'd1},
        {8'h02, 8'd5,  8'd0,  8'd2},
        {8'hAB, 8'd0,  8'd0,  8'd3},
        {8'h0B, 8'd60, 8'd20, 8'd0}
    };

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h00, d); chk(d == 0, "R1", "ctrl after reset", d, 0);
        rd(8'h48, d); chk(d == 0, "R1", "tx count after reset", d, 0);
        rd(8'h4B, d); chk(d == 0, "R1", "rx count after reset", d, 0);
        rd(8'h80, d); chk(d == 0, "R1", "buffer byte after reset", d, 0);
        chk(spi_cs_n == 4'hF && !spi_sclk && !spi_mosi, "R1", "pins after reset",
            {spi_cs_n, spi_sclk, spi_mosi}, 6'h3C);

        // R2: chip-select index keeps only bits [1:0]; out-of-map reads zero
        wr(8'h1D, 32'hFF);
        rd(8'h1D, d); chk(d == 32'h3, "R2", "select index width", d, 3);
        rd(8'hC6, d); chk(d == 0, "R2", "address past buffer", d, 0);

        // table of commands
        for (int v = 0; v < 5; v++) begin
            logic [7:0] op, tx, rx, cs;
            int bad, exp_n;
            string rq;
            {op, tx, rx, cs} = VEC[v];
            for (int i = 0; i < int'(tx); i++) wr(8'(8'h80 + i), {24'h0, pat(v, i)});
            launch(op, cs[1:0], tx, rx, 1'b1);
            wait_idle();
            exp_n = 1 + int'(tx) + int'(rx);
            rq = (exp_n == 1) ? "R11" : (int'(tx) + int'(rx) > 70) ? "R10" : "R4";
            chk(nbytes == exp_n, rq, "bytes on wire", nbytes, exp_n);
            chk(mosi_log[0] == op, "R4", "opcode first", mosi_log[0], op);
            bad = 0;
            for (int i = 0; i < int'(tx); i++) if (mosi_log[1 + i] != pat(v, i)) bad++;
            chk(bad == 0, "R4", "payload bytes", bad, 0);
            bad = 0;
            for (int i = 0; i < int'(rx); i++) if (mosi_log[1 + int'(tx) + i] != 8'h00) bad++;
            chk(bad == 0, "R6", "MOSI zero while receiving", bad, 0);
            bad = 0;
            for (int i = 0; i < int'(rx) && int'(tx) + i < 70; i++) begin
                rd(8'(8'h80 + int'(tx) + i), d);
                if (d[7:0] != resp(1 + int'(tx) + i)) bad++;
            end
            chk(bad == 0, (int'(tx) + int'(rx) > 70) ? "R10" : "R5", "stored response", bad, 0);
            bad = 0;
            for (int i = 0; i < int'(tx); i++) begin
                rd(8'(8'h80 + i), d);
                if (d[7:0] != pat(v, i)) bad++;
            end
            chk(bad == 0, "R6", "payload kept, early MISO discarded", bad, 0);
            chk(lowmask == (4'h1 << cs[1:0]) && cs_falls == 1, "R3", "select line",
                {cs_falls, lowmask}, {32'd1, 4'h1 << cs[1:0]});
            rd(8'h00, d); chk(d == {24'h0, op}, "R2", "ctrl readback, exec self-clears", d, op);
        end

        // R7: serial clock shape
        chk(hi_min == 2 && hi_max == 2, "R7", "SCLK high time", {hi_min, hi_max}, {32'd2, 32'd2});
        chk(min_int == 4, "R7", "SCLK period", min_int, 4);

        // R9: writes during a command are ignored
        wr(8'h80, 32'h11); wr(8'h81, 32'h22);
        launch(8'h3C, 2'd1, 8'd2, 8'd1, 1'b1);
        wr(8'h80, 32'h99);
        wr(8'h48, 32'h5);
        wr(8'h4B, 32'h5);
        wr(8'h1D, 32'h2);
        wr(8'h00, 32'h0011_0077);
        wait_idle();
        rd(8'h48, d); chk(d == 2, "R9", "tx count held", d, 2);
        rd(8'h4B, d); chk(d == 1, "R9", "rx count held", d, 1);
        rd(8'h1D, d); chk(d == 1, "R9", "select held", d, 1);
        rd(8'h00, d); chk(d == 32'h3C, "R9", "opcode held", d, 32'h3C);
        rd(8'h80, d); chk(d == 32'h11, "R9", "buffer held", d, 32'h11);
        chk(nbytes == 4 && mosi_log[1] == 8'h11 && cs_falls == 1, "R9", "command undisturbed",
            {nbytes, mosi_log[1], cs_falls}, {32'd4, 8'h11, 32'd1});

        // R8: without clear the next command starts at index 3 (2 out + 1 in)
        wr(8'h83, 32'hC7);
        launch(8'h44, 2'd0, 8'd1, 8'd0, 1'b0);
        wait_idle();
        chk(mosi_log[1] == 8'hC7, "R8", "payload from left pointer", mosi_log[1], 8'hC7);
        launch(8'h44, 2'd0, 8'd1, 8'd0, 1'b1);
        wait_idle();
        chk(mosi_log[1] == 8'h11, "R8", "payload after clear", mosi_log[1], 8'h11);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule